// File: doc/BRIEF.md
# Burst-Correcting Cyclic Check Generator

This block computes a 32-bit cyclic check over a serial bit stream made of 16-bit words, each sent most significant bit first. The sync word is not part of the stream it sees. In write mode one 32-bit register divides the data, premultiplied by X^32, by the generator X^32+X^23+X^21+X^11+X^2+1. After the last data bit, an append control shifts the 32 remainder bits out behind the data. They form two extra words.

The generator is the product of (X^11+X^2+1) and (X^21+1). In read mode the same 32 storage bits split into two independent registers, one for each factor. The whole received stream, including the two appended words, is reduced modulo X^21+1 in the upper 21 bits. In the lower 11 bits it is reduced modulo X^11+X^2+1, with premultiplication by X^11. A clean block leaves both remainders at zero. Two flags summarise the syndrome for the correction software that follows. Any single burst of 11 bits or fewer is correctable in records up to 42,987 bits, the product of the two factor periods.

Top module: `burst_ecc_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the syndrome is zero and both flags are low.
- R2: A high `clr` zeroes all 32 state bits on that edge, whatever `bit_vld`, `mode` and `append` are.
- R3: With `bit_vld` low and `clr` low, the state holds and does not depend on `bit_in`.
- R4: In write mode (`mode`=0) with `append` low, each valid bit updates the state. After the message, the state equals M(x)·X^32 mod G(x), where G = X^32+X^23+X^21+X^11+X^2+1 and bit 31 holds the X^31 coefficient.
- R5: In write mode with `append` high, `bit_out` equals state bit 31. Each valid bit shifts the state left and fills bit 0 with zero, so 32 append bits emit the remainder, X^31 coefficient first, and leave the state zero.
- R6: Outside write-mode append, `bit_out` equals `bit_in`.
- R7: A codeword made of a message followed by its appended remainder, fed in read mode (`mode`=1) after a clear, leaves the syndrome zero.
- R8: In read mode, `syndrome[31:11]` holds the received polynomial mod X^21+1, with bit 11+k holding the X^k coefficient.
- R9: In read mode, `syndrome[10:0]` holds (received polynomial · X^11) mod (X^11+X^2+1), with bit k holding the X^k coefficient.
- R10: `syn_nz` is high when any syndrome bit is set. `uncorrectable` is high when exactly one of the two remainder fields is nonzero.
- R11: In read mode, `append` has no effect on the state or on `bit_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zeroes the state at block start |
| bit_vld | input | 1 | Strobe: `bit_in` carries a valid bit this cycle |
| bit_in | input | 1 | Serial data in |
| mode | input | 1 | 0 = write (encode), 1 = read (split check) |
| append | input | 1 | Write mode: shift the remainder out |
| bit_out | output | 1 | Serial data out: pass-through or remainder bit |
| syndrome | output | 32 | State: write remainder, or split read remainders |
| syn_nz | output | 1 | Some syndrome bit is set |
| uncorrectable | output | 1 | Exactly one remainder field is nonzero |

## Verification
The hardest state to reach from the ports is a received block that leaves one factor remainder at zero while the other stays nonzero. Only that case raises `uncorrectable`, and ordinary burst errors never produce it. The stimulus reaches it with an error pattern equal to X^21+1 added to a valid codeword. That pattern vanishes modulo the long factor but not modulo the 11-bit factor. Burst patterns that upset both remainders, and clean codewords built by the block's own append phase, complete the read-side cases.

// File: rtl/bec_pkg.sv
package bec_pkg;
    localparam int WORD_W    = 16;
    localparam int SHORT_DEG = 11;
    localparam int LONG_DEG  = 21;
    localparam int CHK_W     = SHORT_DEG + LONG_DEG;

    // full polynomials including the leading term
    localparam logic [SHORT_DEG:0] SHORT_POLY = {1'b1, {(SHORT_DEG-3){1'b0}}, 3'b101};
    localparam logic [LONG_DEG:0]  LONG_POLY  = {1'b1, {(LONG_DEG-1){1'b0}}, 1'b1};

    // carry-less product of the two factors gives the write generator
    function automatic logic [CHK_W:0] clmul(input logic [SHORT_DEG:0] a,
                                             input logic [LONG_DEG:0]  b);
        logic [CHK_W:0] acc;
        acc = '0;
        for (int i = 0; i <= SHORT_DEG; i++) begin
            if (a[i]) acc = acc ^ ({{(CHK_W-LONG_DEG){1'b0}}, b} << i);
        end
        return acc;
    endfunction

    localparam logic [CHK_W:0] FULL_POLY = clmul(SHORT_POLY, LONG_POLY);

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } bec_mode_e;

    typedef struct packed {
        logic [LONG_DEG-1:0]  long_rem;
        logic [SHORT_DEG-1:0] short_rem;
    } bec_split_t;
endpackage

// File: rtl/bec_write_step.sv
module bec_write_step #(
    parameter int W = bec_pkg::CHK_W,
    parameter logic [W-1:0] TAPS = bec_pkg::FULL_POLY[bec_pkg::CHK_W-1:0]
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    input  logic         shift_out,
    output logic [W-1:0] nxt
);
    logic fb;

    always_comb begin
        // premultiplied division: feedback is register MSB xor data
        fb  = shift_out ? 1'b0 : (cur[W-1] ^ din);
        nxt = {cur[W-2:0], 1'b0} ^ (fb ? TAPS : '0);
    end
endmodule

// File: rtl/bec_read_step.sv
module bec_read_step #(
    parameter int LDEG = bec_pkg::LONG_DEG,
    parameter int SDEG = bec_pkg::SHORT_DEG,
    parameter logic [SDEG-1:0] STAPS = bec_pkg::SHORT_POLY[bec_pkg::SHORT_DEG-1:0]
) (
    input  logic [LDEG-1:0] long_cur,
    input  logic [SDEG-1:0] short_cur,
    input  logic            din,
    output logic [LDEG-1:0] long_nxt,
    output logic [SDEG-1:0] short_nxt
);
    logic s_fb;

    always_comb begin
        // X^LDEG + 1: plain reduction, top bit wraps into bit 0
        long_nxt  = {long_cur[LDEG-2:0], long_cur[LDEG-1] ^ din};
        // short factor with X^SDEG premultiplication
        s_fb      = short_cur[SDEG-1] ^ din;
        short_nxt = {short_cur[SDEG-2:0], 1'b0} ^ (s_fb ? STAPS : '0);
    end
endmodule

// File: rtl/bec_classify.sv
module bec_classify
    import bec_pkg::*;
(
    input  bec_split_t st,
    output logic       any_nz,
    output logic       one_sided
);
    logic l_nz, s_nz;

    always_comb begin
        l_nz      = |st.long_rem;
        s_nz      = |st.short_rem;
        any_nz    = l_nz | s_nz;
        one_sided = l_nz ^ s_nz;
    end
endmodule

// File: rtl/burst_ecc_gen.sv
module burst_ecc_gen
    import bec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             mode,
    input  logic             append,
    output logic             bit_out,
    output logic [CHK_W-1:0] syndrome,
    output logic             syn_nz,
    output logic             uncorrectable
);
    bec_mode_e        mode_e;
    bec_split_t       state_q;
    logic [CHK_W-1:0] wr_nxt;
    bec_split_t       rd_nxt;
    logic             shifting;

    assign mode_e   = bec_mode_e'(mode);
    assign shifting = (mode_e == MODE_WRITE) && append;

    bec_write_step u_wr (
        .cur       (state_q),
        .din       (bit_in),
        .shift_out (shifting),
        .nxt       (wr_nxt)
    );

    bec_read_step u_rd (
        .long_cur  (state_q.long_rem),
        .short_cur (state_q.short_rem),
        .din       (bit_in),
        .long_nxt  (rd_nxt.long_rem),
        .short_nxt (rd_nxt.short_rem)
    );

    bec_classify u_cls (
        .st        (state_q),
        .any_nz    (syn_nz),
        .one_sided (uncorrectable)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= '0;
        end else if (bit_vld) begin
            if (mode_e == MODE_WRITE) state_q <= wr_nxt;
            else                      state_q <= rd_nxt;
        end
    end

    assign bit_out  = shifting ? state_q[CHK_W-1] : bit_in;
    assign syndrome = state_q;
endmodule

// File: rtl/burst_ecc_gen_chk.sv
module burst_ecc_gen_chk
    import bec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             bit_vld,
    input logic             bit_in,
    input logic             mode,
    input logic             append,
    input logic             bit_out,
    input logic [CHK_W-1:0] syndrome,
    input logic             syn_nz,
    input logic             uncorrectable
);
    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> syndrome == '0); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst) clr |=> syndrome == '0); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!bit_vld && !clr) |=> $stable(syndrome)); // R3
    AST_APPEND_TAP: assert property (@(posedge clk) disable iff (rst) (mode == 1'b0 && append) |-> bit_out == syndrome[CHK_W-1]); // R5
    AST_APPEND_SHIFT: assert property (@(posedge clk) disable iff (rst) (mode == 1'b0 && append && bit_vld && !clr) |=> syndrome == {$past(syndrome[CHK_W-2:0]), 1'b0}); // R5
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst) !(mode == 1'b0 && append) |-> bit_out == bit_in); // R6
    AST_FLAG_NZ: assert property (@(posedge clk) disable iff (rst) syn_nz == (syndrome != '0)); // R10
    AST_FLAG_ONESIDE: assert property (@(posedge clk) disable iff (rst) uncorrectable |-> syn_nz); // R10
    AST_READ_LONG_SHIFT: assert property (@(posedge clk) disable iff (rst) (mode == 1'b1 && bit_vld && !clr) |=> syndrome[CHK_W-1:SHORT_DEG+1] == $past(syndrome[CHK_W-2:SHORT_DEG])); // R8
endmodule

bind burst_ecc_gen burst_ecc_gen_chk u_chk (.*);

// File: tb/burst_ecc_gen_test.sv
`timescale 1ns/1ps
module burst_ecc_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1, clr = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
    logic        mode = 1'b0, append = 1'b0;
    logic        bit_out, syn_nz, uncorrectable;
    logic [31:0] syndrome;
    logic        obs;
    int          checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    burst_ecc_gen uut (.*);

    typedef struct packed { logic [31:0] msg; logic [63:0] err; } vec_t;
    localparam vec_t VECS [4] = '{
        '{32'h0000_0000, 64'h0},
        '{32'hA5C3_0F1E, 64'h0},
        '{32'h1234_8001, 64'h0000_0000_0700_0000},
        '{32'hFFFF_0001, 64'h0000_0000_0020_0001}
    };

    // long division of msg*X^32 by the generator
    function automatic logic [31:0] crc_ref(input logic [31:0] m);
        logic [63:0] v = {m, 32'b0};
        for (int i = 63; i >= 32; i--)
            if (v[i]) v = v ^ ({31'b0, 33'h1_00A0_0805} << (i - 32));
        return v[31:0];
    endfunction

    function automatic logic [20:0] long_ref(input logic [63:0] cw);
        logic [20:0] r = '0;
        for (int i = 0; i < 64; i++) if (cw[i]) r[i % 21] = ~r[i % 21];
        return r;
    endfunction

    function automatic logic [10:0] short_ref(input logic [63:0] cw);
        logic [74:0] v = {cw, 11'b0};
        for (int i = 74; i >= 11; i--)
            if (v[i]) v = v ^ ({63'b0, 12'h805} << (i - 11));
        return v[10:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic c, input logic v, input logic d, input logic a);
        @(negedge clk);
        clr = c; bit_vld = v; bit_in = d; append = a;
        #0.5 obs = bit_out;
        @(posedge clk);
        #0.5;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] crc, cap;
        logic [63:0] cw;
        logic [31:0] exp_syn;
        int          pass_bad;

        repeat (3) tick(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R1 syndrome", syndrome, 0);
        chk("R1 flags", {syn_nz, uncorrectable}, 0);
        @(negedge clk) rst = 1'b0;

        // table walk: encode, append, then check the received block
        foreach (VECS[k]) begin
            mode = 1'b0;
            tick(1'b1, 1'b0, 1'b0, 1'b0);
            crc = crc_ref(VECS[k].msg);
            pass_bad = 0;
            for (int i = 31; i >= 0; i--) begin
                tick(1'b0, 1'b1, VECS[k].msg[i], 1'b0);
                if (obs !== VECS[k].msg[i]) pass_bad++;
            end
            chk("R6 data pass-through", pass_bad, 0);
            chk("R4 write remainder", syndrome, crc);
            for (int i = 31; i >= 0; i--) begin
                tick(1'b0, 1'b1, 1'b1, 1'b1);
                cap[i] = obs;
            end
            chk("R5 appended bits", cap, crc);
            chk("R5 state after append", syndrome, 0);

            mode = 1'b1;
            tick(1'b1, 1'b0, 1'b0, 1'b0);
            cw = {VECS[k].msg, cap} ^ VECS[k].err;
            for (int i = 63; i >= 0; i--) tick(1'b0, 1'b1, cw[i], 1'b0);
            exp_syn = {long_ref(cw), short_ref(cw)};
            if (VECS[k].err == 0) chk("R7 clean codeword", syndrome, 0);
            chk("R8 long remainder", syndrome[31:11], exp_syn[31:11]);
            chk("R9 short remainder", syndrome[10:0], exp_syn[10:0]);
            chk("R10 flags", {syn_nz, uncorrectable},
                {exp_syn != 0, (exp_syn[31:11] != 0) ^ (exp_syn[10:0] != 0)});
        end

        // R2: clear in the middle of a stream, with a valid bit present
        mode = 1'b0;
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, i[0] ^ i[2], 1'b0);
        tick(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R2 clear mid-stream", syndrome, 0);

        // R3: idle cycles with toggling data leave the state alone
        for (int i = 15; i >= 0; i--) tick(1'b0, 1'b1, 16'hBEEF >> i, 1'b0);
        for (int i = 0; i < 6; i++) begin
            tick(1'b0, 1'b0, i[0], 1'b0);
            if (i == 0) chk("R6 idle pass-through", obs, i[0]);
        end
        chk("R3 hold while idle", syndrome, crc_ref({16'b0, 16'hBEEF}));

        // R11: append held high in read mode changes nothing
        mode = 1'b1;
        tick(1'b1, 1'b0, 1'b0, 1'b0);
        cw = {32'hA5C3_0F1E, crc_ref(32'hA5C3_0F1E)} ^ 64'h0000_1000_0000_0000;
        pass_bad = 0;
        for (int i = 63; i >= 0; i--) begin
            tick(1'b0, 1'b1, cw[i], 1'b1);
            if (obs !== cw[i]) pass_bad++;
        end
        chk("R11 bit_out in read append", pass_bad, 0);
        chk("R11 syndrome in read append", syndrome, {long_ref(cw), short_ref(cw)});

        // R1: reset from a nonzero state
        @(negedge clk) rst = 1'b1;
        tick(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R1 reset from busy state", syndrome, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule